// File: doc/BRIEF.md
# Interrupt Request Dispatch Router

This block sits between a set of peripheral interrupt flags and the three agents that may service them: a DMA controller, a data-transfer controller (DTC) and the CPU interrupt input. Each source has three control bits, plus one global DMA enable, and these bits choose which agent gets the request. The block also decides when the source flag is cleared, and when a finished transfer is turned into a CPU interrupt. The transfer engines and the priority arbiter stay outside. The block only activates them and reacts to their handshakes.

A source that is selected for DMA while the global DMA enable is set is hidden from the DTC and from the CPU. The DMA controller sees a level request, and the source flag is cleared when the controller reports that the transfer has started. A source with its DTC enable set gets one activation pulse per request. When the DTC reports the transfer as done, the action depends on two things:

- the source's interrupt-select bit;
- the counter-zero flag that comes with the done strobe.

The block may clear the source, it may clear the DTC enable, and it may raise a CPU interrupt. Any other source goes straight to the CPU. The CPU interrupt output is the OR of per-source pending flags, and the CPU clears each flag with its own strobe.

Top module: `irq_dispatch_router`

## Requirements
- R1: After reset, every output is low and every control bit is cleared. A request on any source then reaches the CPU interrupt output.
- R2: When a source is not routed to the DMA controller and its DTC enable is 0, its request raises `cpu_irq` within three cycles.
- R3: `cpu_irq` is the OR of the per-source pending flags. A `cpu_clr` strobe drops a flag only if no new set condition occurs in the same cycle. While the request is still held, the flag is set again, and a set in the same cycle as a clear wins.
- R4: A write to address i < NSRC stores the source control bits: bit 0 selects DMA, bit 1 is the DTC enable and bit 2 is the interrupt select. A write to address NSRC stores the global DMA enable in bit 0. With both DMA select and the global enable at 1, the request appears only on `dma_act`. No DTC activation and no CPU interrupt are produced for it, whatever the DTC enable is. With the global enable at 0, the source is routed as if DMA were not selected.
- R5: A `dma_start` strobe for a DMA-routed source gives a one-cycle `src_clr` pulse on the next cycle, and `dma_act` drops at once.
- R6: With the DTC enable at 1, a pending request gives exactly one `dtc_act` pulse. There is no further pulse and no CPU interrupt until `dtc_done` returns for that source.
- R7: With interrupt select at 1, a done strobe clears the DTC enable and raises a CPU interrupt. It does not pulse `src_clr`, so the source stays pending.
- R8: With interrupt select at 0 and counter-zero at 0, a done strobe pulses `src_clr` and raises no CPU interrupt. The DTC enable stays 1, so the next request activates the DTC again.
- R9: With interrupt select at 0 and counter-zero at 1, a done strobe pulses `src_clr`, clears the DTC enable and raises a CPU interrupt.
- R10: A `dtc_done` strobe for a source that has no outstanding activation is ignored. It causes no clear, no interrupt and no change to the DTC enable.
- R11: A register write that lands in the same cycle as a hardware clear of the DTC enable wins, so the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_addr | input | AW | Write address: a source index, or NSRC for the global DMA enable |
| reg_wr_data | input | 3 | Write data (field layout in R4) |
| src_req | input | NSRC | Level request flag of each peripheral source |
| src_clr | output | NSRC | One-cycle clear pulse back to each source |
| dma_act | output | NSRC | Level activation request to the DMA controller |
| dma_start | input | NSRC | DMA controller reports the start of a transfer for a source |
| dtc_act | output | NSRC | One-cycle activation pulse to the DTC |
| dtc_done | input | NSRC | DTC reports a completed transfer for a source |
| dtc_cnt_zero | input | 1 | Qualifies `dtc_done`: the transfer counter reached zero |
| cpu_clr | input | NSRC | Per-source clear strobe for the CPU-pending flag |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes each with a directed case:

- **Pending flag, set against clear.** A done strobe with counter-zero sets a source's CPU-pending flag, and a `cpu_clr` for that source arrives in the same cycle. The source flag has already been cleared by `src_clr`, so `cpu_irq` can stay high only if the set won. The bench judges the case by that level.
- **DTC enable, write against hardware clear.** A done strobe that clears the DTC enable meets a register write that sets the enable again. The bench judges the outcome by whether the next request produces a fresh `dtc_act` pulse rather than a CPU interrupt.

Random transactions over sources, modes and counter-zero values surround these directed cases.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int CTRL_W      = 3;
  localparam int BIT_DMA_SEL = 0;
  localparam int BIT_DTC_EN  = 1;
  localparam int BIT_ISEL    = 2;

  typedef struct packed {
    logic isel;
    logic dtc_en;
    logic dma_sel;
  } src_ctrl_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_route_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int AW  = $clog2(NSRC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [NSRC-1:0]   en_clr,
  output src_ctrl_t         ctrl [NSRC],
  output logic              dma_en
);
  src_ctrl_t ctrl_q [NSRC];
  src_ctrl_t ctrl_n [NSRC];
  logic      dma_en_q, dma_en_n;
  logic      glob_hit;

  assign glob_hit = wr_en && (wr_addr == AW'(NSRC));

  always_comb begin
    dma_en_n = glob_hit ? wr_data[0] : dma_en_q;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(i));

    // software write overrides the hardware clear of the same cycle
    always_comb begin
      ctrl_n[i] = ctrl_q[i];
      if (hit) begin
        ctrl_n[i] = src_ctrl_t'(wr_data);
      end else if (en_clr[i]) begin
        ctrl_n[i].dtc_en = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[i] <= '0;
      else        ctrl_q[i] <= ctrl_n[i];
    end

    assign ctrl[i] = ctrl_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_en_q <= 1'b0;
    else        dma_en_q <= dma_en_n;
  end

  assign dma_en = dma_en_q;
endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic route_dma,
  input  logic dtc_en,
  input  logic isel,
  input  logic src_req,
  input  logic dma_start,
  input  logic dtc_done,
  input  logic cnt_zero,
  input  logic cpu_clr,
  output logic src_clr,
  output logic dma_act,
  output logic dtc_act,
  output logic cpu_pend,
  output logic en_clr,
  output logic busy
);
  logic busy_q, busy_n;
  logic hold_q, hold_n;     // a clear was issued; wait for the flag to drop
  logic pend_q, pend_n;
  logic act_q, act_n;
  logic clr_q, clr_n;
  logic route_dtc, route_cpu, fire, done_ok, irq_from_dtc, cpu_set;

  assign route_dtc    = !route_dma && dtc_en;
  assign route_cpu    = !route_dma && !dtc_en;
  assign fire         = route_dtc && src_req && !busy_q && !hold_q;
  assign done_ok      = dtc_done && busy_q;
  assign irq_from_dtc = done_ok && (isel || cnt_zero);
  assign cpu_set      = irq_from_dtc || (route_cpu && src_req && !hold_q);

  always_comb begin
    busy_n = busy_q;
    if (fire)         busy_n = 1'b1;
    else if (done_ok) busy_n = 1'b0;

    act_n = fire;
    clr_n = (done_ok && !isel) || (route_dma && dma_start && !hold_q);

    hold_n = hold_q && src_req;
    if (clr_n) hold_n = 1'b1;

    pend_n = pend_q;
    if (cpu_set)      pend_n = 1'b1;
    else if (cpu_clr) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      hold_q <= hold_n;
      pend_q <= pend_n;
      act_q  <= act_n;
      clr_q  <= clr_n;
    end
  end

  assign src_clr  = clr_q;
  assign dtc_act  = act_q;
  assign dma_act  = route_dma && src_req && !hold_q;
  assign cpu_pend = pend_q && !route_dma;
  assign en_clr   = irq_from_dtc;
  assign busy     = busy_q;
endmodule

// File: rtl/irq_dispatch_router.sv
module irq_dispatch_router
  import irq_route_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int AW  = $clog2(NSRC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [AW-1:0]     reg_wr_addr,
  input  logic [CTRL_W-1:0] reg_wr_data,
  input  logic [NSRC-1:0]   src_req,
  output logic [NSRC-1:0]   src_clr,
  output logic [NSRC-1:0]   dma_act,
  input  logic [NSRC-1:0]   dma_start,
  output logic [NSRC-1:0]   dtc_act,
  input  logic [NSRC-1:0]   dtc_done,
  input  logic              dtc_cnt_zero,
  input  logic [NSRC-1:0]   cpu_clr,
  output logic              cpu_irq
);
  logic            rst_int_n;
  src_ctrl_t       ctrl [NSRC];
  logic            dma_en;
  logic [NSRC-1:0] en_clr_vec, pend_vec, busy_vec, isel_vec, dma_route_vec;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_ctrl_regs #(.NSRC(NSRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .en_clr  (en_clr_vec),
    .ctrl    (ctrl),
    .dma_en  (dma_en)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_slice
    assign dma_route_vec[i] = ctrl[i].dma_sel && dma_en;
    assign isel_vec[i]      = ctrl[i].isel;

    irq_src_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .route_dma (dma_route_vec[i]),
      .dtc_en    (ctrl[i].dtc_en),
      .isel      (ctrl[i].isel),
      .src_req   (src_req[i]),
      .dma_start (dma_start[i]),
      .dtc_done  (dtc_done[i]),
      .cnt_zero  (dtc_cnt_zero),
      .cpu_clr   (cpu_clr[i]),
      .src_clr   (src_clr[i]),
      .dma_act   (dma_act[i]),
      .dtc_act   (dtc_act[i]),
      .cpu_pend  (pend_vec[i]),
      .en_clr    (en_clr_vec[i]),
      .busy      (busy_vec[i])
    );
  end

  assign cpu_irq = |pend_vec;
endmodule

// File: rtl/irq_dispatch_router_chk.sv
module irq_dispatch_router_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] src_clr,
  input logic [NSRC-1:0] dma_act,
  input logic [NSRC-1:0] dma_start,
  input logic [NSRC-1:0] dtc_act,
  input logic [NSRC-1:0] dtc_done,
  input logic            cpu_irq,
  input logic [NSRC-1:0] busy_vec,
  input logic [NSRC-1:0] isel_vec,
  input logic [NSRC-1:0] dma_route_vec
);
  // R6
  dtc_act_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtc_act & $past(dtc_act)) == '0);

  // R4
  no_dual_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtc_act & dma_act) == '0);

  // R3
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past((|src_req) || (|dtc_done) || reg_wr_en));

  // R7
  isel_keeps_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dtc_done & busy_vec & isel_vec) & src_clr) == '0);

  // R5
  dma_start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dma_start & dma_route_vec & src_req) & ~src_clr & ~$past(src_clr)) == '0);
endmodule

bind irq_dispatch_router irq_dispatch_router_chk #(.NSRC(NSRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .src_req       (src_req),
  .src_clr       (src_clr),
  .dma_act       (dma_act),
  .dma_start     (dma_start),
  .dtc_act       (dtc_act),
  .dtc_done      (dtc_done),
  .cpu_irq       (cpu_irq),
  .busy_vec      (busy_vec),
  .isel_vec      (isel_vec),
  .dma_route_vec (dma_route_vec)
);

// File: tb/test_irq_dispatch_router.sv
module test_irq_dispatch_router;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [2:0]    wr_data = '0;
  logic [N-1:0]  periph, set_req = '0, man_clr = '0;
  logic [N-1:0]  src_clr, dma_act, dtc_act;
  logic [N-1:0]  dma_start = '0, dtc_done = '0, cpu_clr = '0;
  logic          cnt_zero = 1'b0;
  logic          cpu_irq;

  int tests = 0;
  int fails = 0;
  int act_cnt [N];
  int clr_cnt [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch_router #(.NSRC(N)) i_irq_dispatch_router (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (wr_en), .reg_wr_addr (wr_addr), .reg_wr_data (wr_data),
    .src_req (periph), .src_clr (src_clr),
    .dma_act (dma_act), .dma_start (dma_start),
    .dtc_act (dtc_act), .dtc_done (dtc_done), .dtc_cnt_zero (cnt_zero),
    .cpu_clr (cpu_clr), .cpu_irq (cpu_irq)
  );

  // peripheral flag model: set by the bench, cleared by the block or by software
  always @(posedge clk) begin
    if (!rst_n) periph <= '0;
    else        periph <= (periph | set_req) & ~(src_clr | man_clr);
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        act_cnt[i] <= 0;
        clr_cnt[i] <= 0;
      end else begin
        if (dtc_act[i]) act_cnt[i] <= act_cnt[i] + 1;
        if (src_clr[i]) clr_cnt[i] <= clr_cnt[i] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [2:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic raise(input int s);
    set_req[s] = 1'b1; tick(1); set_req[s] = 1'b0;
  endtask

  task automatic drop(input int s);
    man_clr[s] = 1'b1; tick(1); man_clr[s] = 1'b0;
  endtask

  task automatic clr_cpu(input int s);
    cpu_clr[s] = 1'b1; tick(1); cpu_clr[s] = 1'b0;
  endtask

  task automatic done(input int s, input bit z);
    dtc_done[s] = 1'b1; cnt_zero = z; tick(1);
    dtc_done[s] = 1'b0; cnt_zero = 1'b0;
  endtask

  task automatic wait_act(input int s, output bit got);
    got = 1'b0;
    for (int k = 0; k < 20 && !got; k++) begin
      tick(1);
      if (dtc_act[s]) got = 1'b1;
    end
  endtask

  function automatic bit exp_irq(input bit isel, input bit z);
    return isel || z;
  endfunction

  function automatic string dtc_tag(input bit isel, input bit z);
    return isel ? "R7" : (z ? "R9" : "R8");
  endfunction

  task automatic cpu_txn(input int s);
    reg_write(s, 3'b000);
    raise(s); tick(3);
    chk_eq("R2 direct request raises cpu_irq", cpu_irq, 1);
    clr_cpu(s); tick(2);
    chk_eq("R3 clear while request held", cpu_irq, 1);
    drop(s); clr_cpu(s); tick(2);
    chk_eq("R3 clear after request gone", cpu_irq, 0);
  endtask

  task automatic dma_txn(input int s);
    int a0, c0;
    reg_write(N, 3'b001);
    reg_write(s, 3'b011);
    a0 = act_cnt[s]; c0 = clr_cnt[s];
    raise(s); tick(3);
    chk_eq("R4 dma_act asserted", dma_act[s], 1);
    chk_eq("R4 cpu_irq masked", cpu_irq, 0);
    chk_eq("R4 no dtc activation", act_cnt[s] - a0, 0);
    dma_start[s] = 1'b1; tick(1); dma_start[s] = 1'b0;
    tick(3);
    chk_eq("R5 source cleared", periph[s], 0);
    chk_eq("R5 dma_act dropped", dma_act[s], 0);
    chk_eq("R5 one clear pulse", clr_cnt[s] - c0, 1);
    reg_write(N, 3'b000);
    reg_write(s, 3'b000);
    tick(2);
  endtask

  task automatic dtc_txn(input int s, input bit isel, input bit z);
    int a0, c0;
    bit got;
    string tg;
    tg = dtc_tag(isel, z);
    reg_write(s, {isel, 1'b1, 1'b0});
    a0 = act_cnt[s]; c0 = clr_cnt[s];
    raise(s); wait_act(s, got);
    chk_eq("R6 activation pulse seen", got, 1);
    tick(3);
    chk_eq("R6 single activation while busy", act_cnt[s] - a0, 1);
    chk_eq("R6 no cpu_irq during transfer", cpu_irq, 0);
    done(s, z); tick(4);
    chk_eq({tg, " cpu_irq after done"}, cpu_irq, exp_irq(isel, z));
    chk_eq({tg, " source flag after done"}, periph[s], isel);
    chk_eq({tg, " clear pulses"}, clr_cnt[s] - c0, isel ? 0 : 1);
    if (!isel && !z) begin
      raise(s); wait_act(s, got);
      chk_eq("R8 enable kept, reactivated", got, 1);
      tick(2); done(s, 1'b0); tick(4);
    end else begin
      drop(s); clr_cpu(s); tick(3);
      chk_eq("R3 pending flag cleared", cpu_irq, 0);
      a0 = act_cnt[s];
      raise(s); tick(4);
      chk_eq({tg, " enable cleared, no reactivation"}, act_cnt[s] - a0, 0);
      chk_eq({tg, " request now to cpu"}, cpu_irq, 1);
      drop(s); clr_cpu(s); tick(3);
    end
  endtask

  initial begin
    int a0, c0, s, m;
    bit got;
    void'($urandom(32'd1977));
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk_eq("R1 cpu_irq low", cpu_irq, 0);
    chk_eq("R1 dtc_act low", dtc_act, 0);
    chk_eq("R1 dma_act low", dma_act, 0);
    chk_eq("R1 src_clr low", src_clr, 0);
    raise(0); tick(3);
    chk_eq("R1 cleared control routes to cpu", cpu_irq, 1);
    drop(0); clr_cpu(0); tick(2);

    // R3 OR of two sources
    raise(1); raise(2); tick(3);
    drop(1); clr_cpu(1); tick(2);
    chk_eq("R3 other source keeps cpu_irq", cpu_irq, 1);
    drop(2); clr_cpu(2); tick(2);
    chk_eq("R3 all cleared", cpu_irq, 0);

    // R4 global enable off: dma select alone is not a DMA route
    reg_write(3, 3'b001);
    raise(3); tick(3);
    chk_eq("R4 global off, no dma_act", dma_act[3], 0);
    chk_eq("R4 global off, to cpu", cpu_irq, 1);
    drop(3); clr_cpu(3); reg_write(3, 3'b000); tick(2);

    dma_txn(4);
    dtc_txn(5, 1'b1, 1'b0);
    dtc_txn(6, 1'b0, 1'b0);
    dtc_txn(7, 1'b0, 1'b1);

    // R10 stray done strobes
    c0 = clr_cnt[2];
    done(2, 1'b1); tick(3);
    chk_eq("R10 stray done no irq", cpu_irq, 0);
    chk_eq("R10 stray done no clear", clr_cnt[2] - c0, 0);
    reg_write(2, 3'b010);
    done(2, 1'b1); tick(3);
    chk_eq("R10 stray done with enable, no irq", cpu_irq, 0);
    raise(2); wait_act(2, got);
    chk_eq("R10 enable unchanged by stray done", got, 1);
    tick(2); done(2, 1'b0); tick(4);

    // R3 set wins over cpu_clr in the same cycle
    reg_write(1, 3'b010);
    raise(1); wait_act(1, got); tick(2);
    dtc_done[1] = 1'b1; cnt_zero = 1'b1; cpu_clr[1] = 1'b1;
    tick(1);
    dtc_done[1] = 1'b0; cnt_zero = 1'b0; cpu_clr[1] = 1'b0;
    tick(4);
    chk_eq("R3 set wins over clear", cpu_irq, 1);
    chk_eq("R9 source cleared", periph[1], 0);
    clr_cpu(1); tick(2);

    // R11 write wins over hardware clear of the enable
    reg_write(0, 3'b010);
    raise(0); wait_act(0, got); tick(2);
    dtc_done[0] = 1'b1; cnt_zero = 1'b1;
    wr_en = 1'b1; wr_addr = AW'(0); wr_data = 3'b010;
    tick(1);
    dtc_done[0] = 1'b0; cnt_zero = 1'b0; wr_en = 1'b0;
    tick(4);
    chk_eq("R11 zero count still raises irq", cpu_irq, 1);
    clr_cpu(0); tick(2);
    a0 = act_cnt[0];
    raise(0); wait_act(0, got);
    chk_eq("R11 written enable kept", got, 1);
    tick(2); done(0, 1'b0); tick(4);
    chk_eq("R11 no irq after non-zero done", cpu_irq, 0);
    reg_write(0, 3'b000); reg_write(1, 3'b000); reg_write(2, 3'b000);
    tick(2);

    // random transactions
    for (int it = 0; it < 24; it++) begin
      s = int'($urandom % N);
      m = int'($urandom % 4);
      case (m)
        0: cpu_txn(s);
        1: dtc_txn(s, 1'b0, 1'($urandom % 2));
        2: dtc_txn(s, 1'b1, 1'($urandom % 2));
        default: dma_txn(s);
      endcase
      reg_write(s, 3'b000);
      tick(2);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule